// File: doc/BRIEF.md
# UART Channel Buffering with Automatic Flow Control

This block sits between a UART channel's host register interface and its serial shifters. It holds a 32-entry transmit queue and a 32-entry receive queue. It reports both fill levels and raises level-based interrupt requests against programmable trigger levels. It also makes every flow-control decision for the channel. Serial shifting and baud timing are handled outside the block. The receive shifter delivers finished characters on `ser_rx_valid`/`ser_rx_data`. The transmit shifter takes one character whenever `ser_tx_valid` and `ser_tx_ready` are both high.

Hardware flow control drives `rts_n` from the receive fill level. It uses a halt level and a lower resume level. The halt level is the receive trigger. The resume level is the trigger minus a hysteresis of 0 to 7 entries, floored at zero. `cts_n` is checked only when a new character is handed to the shifter. Software flow control does three things. It removes received XOFF/XON characters and uses them to pause or resume outgoing data. It inserts its own XOFF ahead of queued data when the receive queue reaches the halt level. It sends XON once the queue has drained to the resume level. A programmable special character is stored like ordinary data and also sets a sticky flag.

Four state machines carry the decisions:

- **Remote (RM).** States `RM_GO` and `RM_STOP`.
  - `RM_GO` to `RM_STOP` on a received XOFF.
  - `RM_STOP` to `RM_GO` on a received XON, or when software flow control is disabled.
- **RTS.** States `RTS_ON` and `RTS_OFF`.
  - `RTS_ON` to `RTS_OFF` when auto-RTS is on and the level reaches the halt level.
  - `RTS_OFF` to `RTS_ON` when the resume condition holds or auto-RTS is off.
- **Local flow (LF).** States `LF_RUN`, `LF_SEND_XOFF`, `LF_HELD` and `LF_SEND_XON`.
  - `LF_RUN` to `LF_SEND_XOFF` when the level reaches the halt level.
  - `LF_SEND_XOFF` to `LF_HELD` when the XOFF is taken by the shifter.
  - `LF_HELD` to `LF_SEND_XON` when the resume condition holds.
  - `LF_SEND_XON` to `LF_RUN` when the XON is taken.
  - Any state to `LF_RUN` when software flow control is disabled.
- **Transmit source select.** Choices `TX_XOFF`, `TX_XON`, `TX_DATA` and `TX_NONE`, in that priority order.

Top module: `uart_fifo_flow`

## Requirements
- R1: Each queue holds at most 32 bytes and its level output shows the current count. A host write to a full transmit queue is dropped and leaves `tx_level` at 32.
- R2: A received data character that arrives when the receive queue is full (judged before any same-cycle read) is dropped and sets `overrun`. The flag stays set until `clr_flags`; if a new overrun occurs in the same cycle as `clr_flags`, the flag stays set.
- R3: `rx_irq` is high while `rx_level >= cfg_rx_trig` (valid range 1..32). `tx_irq` is high while `tx_level <= cfg_tx_trig`.
- R4: With `cfg_auto_rts`=1, `rts_n` goes to 1 on the edge after `rx_level` reaches `cfg_rx_trig`. It returns to 0 on the edge after `rx_level` is below `cfg_rx_trig` and at most `cfg_rx_trig - cfg_hyst` (floored at 0). With `cfg_auto_rts`=0, `rts_n` goes to 0 within one edge.
- R5: With `cfg_auto_cts`=1 and `cts_n`=1, `ser_tx_valid` is 0. CTS gates the hand-over only, so a character already taken is never recalled.
- R6: With `cfg_sw_flow`=1, a received byte equal to `cfg_xoff` is not stored and sets `tx_halted` on the next edge; queued data is then not offered. A received `cfg_xon` (not stored) clears `tx_halted`.
- R7: With `cfg_special_en`=1, a received non-flow byte equal to `cfg_special` is stored as data and sets the sticky `special_seen` flag, which `clr_flags` clears.
- R8: With `cfg_sw_flow`=1, once `rx_level` reaches `cfg_rx_trig`, `cfg_xoff` is offered on `ser_tx_data` ahead of any queued byte, even while `tx_halted` is 1.
- R9: After that XOFF has been taken, `cfg_xon` is offered once `rx_level` meets the same resume condition as R4.
- R10: With `cfg_sw_flow`=0, bytes equal to `cfg_xon`/`cfg_xoff` are stored as ordinary data and `tx_halted` stays 0.
- R11: Received bytes are read out on `host_rx_data` in arrival order. Transmit bytes appear on `ser_tx_data` in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rx_trig | input | 6 | Receive trigger and halt level (1..32) |
| cfg_tx_trig | input | 6 | Transmit trigger level |
| cfg_hyst | input | 3 | Distance between halt and resume levels |
| cfg_auto_rts | input | 1 | Enable automatic RTS |
| cfg_auto_cts | input | 1 | Enable CTS gating of transmission |
| cfg_sw_flow | input | 1 | Enable in-band XON/XOFF flow control |
| cfg_xon | input | 8 | XON character value |
| cfg_xoff | input | 8 | XOFF character value |
| cfg_special_en | input | 1 | Enable special-character detection |
| cfg_special | input | 8 | Special character value |
| clr_flags | input | 1 | Clear overrun and special flags |
| host_tx_wr | input | 1 | Host write strobe into transmit queue |
| host_tx_data | input | 8 | Host write data |
| host_rx_rd | input | 1 | Host read strobe, pops receive head |
| host_rx_data | output | 8 | Receive queue head |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 6 | Receive fill count |
| tx_level | output | 6 | Transmit fill count |
| rx_irq | output | 1 | Receive trigger interrupt request |
| tx_irq | output | 1 | Transmit trigger interrupt request |
| ser_rx_valid | input | 1 | Received character strobe |
| ser_rx_data | input | 8 | Received character |
| ser_tx_ready | input | 1 | Transmit shifter can take a character |
| ser_tx_valid | output | 1 | Character offered to the shifter |
| ser_tx_data | output | 8 | Offered character |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| tx_halted | output | 1 | Outgoing data paused by a received XOFF |
| overrun | output | 1 | Sticky receive overrun flag |
| special_seen | output | 1 | Sticky special-character flag |

## Verification
The first pattern fills the transmit queue past capacity with the shifter stalled, then holds CTS inactive. This separates dropped writes from lost ordering and separates CTS gating from an empty queue. The second pattern fills the receive side through the trigger, reads it back in steps, and then pushes it past full. These steps separate the halt edge, the hysteresis band and the resume edge, and show overrun apart from a normal fill. The third pattern runs with software flow control on. It interleaves received XOFF/XON with data while the receive level crosses the trigger. This shows the inserted XOFF overriding a remote pause and the XON following the drain. A final pass with software flow control off confirms that the same byte values become plain data.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    typedef enum logic [1:0] {
        LF_RUN,
        LF_SEND_XOFF,
        LF_HELD,
        LF_SEND_XON
    } lflow_e;

    typedef enum logic {
        RTS_ON,
        RTS_OFF
    } rts_e;

    typedef enum logic {
        RM_GO,
        RM_STOP
    } remote_e;

    typedef enum logic [1:0] {
        TX_NONE,
        TX_XOFF,
        TX_XON,
        TX_DATA
    } txsel_e;

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R1

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == $past(level))); // R1

endmodule

// File: rtl/ufc_rx_filter.sv
module ufc_rx_filter
    import ufc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         sw_en,
    input  logic [W-1:0] xon_char,
    input  logic [W-1:0] xoff_char,
    input  logic         sp_en,
    input  logic [W-1:0] sp_char,
    input  logic         fifo_full,
    input  logic         clr_flags,
    output logic         store,
    output logic         halted,
    output logic         overrun,
    output logic         special_seen
);

    remote_e rm_q, rm_d;
    logic    is_xoff, is_xon;

    assign is_xoff = in_valid && sw_en && (in_data == xoff_char);
    assign is_xon  = in_valid && sw_en && (in_data == xon_char) && !is_xoff;

    always_comb begin
        rm_d = rm_q;
        unique case (rm_q)
            RM_GO:   if (sw_en && is_xoff) rm_d = RM_STOP;
            RM_STOP: if (!sw_en || is_xon)  rm_d = RM_GO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rm_q <= RM_GO;
        else        rm_q <= rm_d;
    end

    always_comb begin
        store  = in_valid && !is_xoff && !is_xon;
        halted = (rm_q == RM_STOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun      <= 1'b0;
            special_seen <= 1'b0;
        end else begin
            if (store && fifo_full)  overrun <= 1'b1;
            else if (clr_flags)      overrun <= 1'b0;
            if (store && sp_en && (in_data == sp_char)) special_seen <= 1'b1;
            else if (clr_flags)                         special_seen <= 1'b0;
        end
    end

    AST_XOFF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sw_en && (in_data == xoff_char)) |=> halted); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_flags) |=> overrun); // R2

endmodule

// File: rtl/ufc_flow_ctrl.sv
module ufc_flow_ctrl
    import ufc_pkg::*;
#(
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] trig,
    input  logic [2:0]    hyst,
    input  logic          auto_rts,
    input  logic          sw_en,
    input  logic          taken_xoff,
    input  logic          taken_xon,
    output logic          rts_n,
    output logic          send_xoff,
    output logic          send_xon
);

    lflow_e        lf_q, lf_d;
    rts_e          rts_q, rts_d;
    logic [LW-1:0] resume;
    logic          halt_hit, resume_ok;

    assign resume    = (trig > LW'(hyst)) ? trig - LW'(hyst) : '0;
    assign halt_hit  = (rx_level >= trig);
    assign resume_ok = (rx_level < trig) && (rx_level <= resume);

    always_comb begin
        lf_d = lf_q;
        if (!sw_en) begin
            lf_d = LF_RUN;
        end else begin
            unique case (lf_q)
                LF_RUN:       if (halt_hit)   lf_d = LF_SEND_XOFF;
                LF_SEND_XOFF: if (taken_xoff) lf_d = LF_HELD;
                LF_HELD:      if (resume_ok)  lf_d = LF_SEND_XON;
                LF_SEND_XON:  if (taken_xon)  lf_d = LF_RUN;
            endcase
        end
    end

    always_comb begin
        rts_d = rts_q;
        unique case (rts_q)
            RTS_ON:  if (auto_rts && halt_hit)    rts_d = RTS_OFF;
            RTS_OFF: if (!auto_rts || resume_ok)  rts_d = RTS_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lf_q  <= LF_RUN;
            rts_q <= RTS_ON;
        end else begin
            lf_q  <= lf_d;
            rts_q <= rts_d;
        end
    end

    always_comb begin
        rts_n     = (rts_q == RTS_OFF);
        send_xoff = (lf_q == LF_SEND_XOFF);
        send_xon  = (lf_q == LF_SEND_XON);
    end

    AST_RTS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts && halt_hit) |=> rts_n); // R4

    AST_XON_AFTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_xon) |-> $past(lf_q == LF_HELD)); // R9

endmodule

// File: rtl/ufc_tx_arb.sv
module ufc_tx_arb
    import ufc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         send_xoff,
    input  logic         send_xon,
    input  logic [W-1:0] xoff_char,
    input  logic [W-1:0] xon_char,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    input  logic         halted,
    input  logic         auto_cts,
    input  logic         cts_n,
    input  logic         tx_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         pop_data,
    output logic         taken_xoff,
    output logic         taken_xon
);

    txsel_e sel;
    logic   cts_ok, taken;

    always_comb begin
        if (send_xoff)                     sel = TX_XOFF;
        else if (send_xon)                 sel = TX_XON;
        else if (!halted && !fifo_empty)   sel = TX_DATA;
        else                               sel = TX_NONE;
    end

    always_comb begin
        cts_ok    = !auto_cts || !cts_n;
        out_valid = cts_ok && (sel != TX_NONE);
        taken     = out_valid && tx_ready;
        out_data  = fifo_head;
        unique case (sel)
            TX_XOFF: out_data = xoff_char;
            TX_XON:  out_data = xon_char;
            TX_DATA: out_data = fifo_head;
            TX_NONE: out_data = fifo_head;
        endcase
        pop_data   = taken && (sel == TX_DATA);
        taken_xoff = taken && (sel == TX_XOFF);
        taken_xon  = taken && (sel == TX_XON);
    end

endmodule

// File: rtl/uart_fifo_flow.sv
module uart_fifo_flow #(
    parameter int  DEPTH = 32,
    parameter int  W     = 8,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] cfg_rx_trig,
    input  logic [LW-1:0] cfg_tx_trig,
    input  logic [2:0]    cfg_hyst,
    input  logic          cfg_auto_rts,
    input  logic          cfg_auto_cts,
    input  logic          cfg_sw_flow,
    input  logic [W-1:0]  cfg_xon,
    input  logic [W-1:0]  cfg_xoff,
    input  logic          cfg_special_en,
    input  logic [W-1:0]  cfg_special,
    input  logic          clr_flags,
    input  logic          host_tx_wr,
    input  logic [W-1:0]  host_tx_data,
    input  logic          host_rx_rd,
    output logic [W-1:0]  host_rx_data,
    output logic          rx_empty,
    output logic [LW-1:0] rx_level,
    output logic [LW-1:0] tx_level,
    output logic          rx_irq,
    output logic          tx_irq,
    input  logic          ser_rx_valid,
    input  logic [W-1:0]  ser_rx_data,
    input  logic          ser_tx_ready,
    output logic          ser_tx_valid,
    output logic [W-1:0]  ser_tx_data,
    input  logic          cts_n,
    output logic          rts_n,
    output logic          tx_halted,
    output logic          overrun,
    output logic          special_seen
);

    logic         rx_store, rx_full;
    logic         tx_full, tx_empty, tx_pop;
    logic [W-1:0] tx_head;
    logic         send_xoff, send_xon, taken_xoff, taken_xon;

    ufc_rx_filter #(.W(W)) u_filter (
        .clk(clk), .rst_n(rst_n),
        .in_valid(ser_rx_valid), .in_data(ser_rx_data),
        .sw_en(cfg_sw_flow), .xon_char(cfg_xon), .xoff_char(cfg_xoff),
        .sp_en(cfg_special_en), .sp_char(cfg_special),
        .fifo_full(rx_full), .clr_flags(clr_flags),
        .store(rx_store), .halted(tx_halted),
        .overrun(overrun), .special_seen(special_seen)
    );

    ufc_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(rx_store), .wdata(ser_rx_data),
        .pop(host_rx_rd), .rdata(host_rx_data),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    ufc_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(host_tx_wr), .wdata(host_tx_data),
        .pop(tx_pop), .rdata(tx_head),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    ufc_flow_ctrl #(.LW(LW)) u_flow (
        .clk(clk), .rst_n(rst_n),
        .rx_level(rx_level), .trig(cfg_rx_trig), .hyst(cfg_hyst),
        .auto_rts(cfg_auto_rts), .sw_en(cfg_sw_flow),
        .taken_xoff(taken_xoff), .taken_xon(taken_xon),
        .rts_n(rts_n), .send_xoff(send_xoff), .send_xon(send_xon)
    );

    ufc_tx_arb #(.W(W)) u_arb (
        .send_xoff(send_xoff), .send_xon(send_xon),
        .xoff_char(cfg_xoff), .xon_char(cfg_xon),
        .fifo_empty(tx_empty), .fifo_head(tx_head),
        .halted(tx_halted), .auto_cts(cfg_auto_cts), .cts_n(cts_n),
        .tx_ready(ser_tx_ready),
        .out_valid(ser_tx_valid), .out_data(ser_tx_data),
        .pop_data(tx_pop), .taken_xoff(taken_xoff), .taken_xon(taken_xon)
    );

    assign rx_irq = (rx_level >= cfg_rx_trig);
    assign tx_irq = (tx_level <= cfg_tx_trig);

    AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_cts && cts_n) |-> !ser_tx_valid); // R5

    AST_TX_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_tx_wr && tx_full && !tx_pop) |=> (tx_level == LW'(DEPTH))); // R1

    AST_HALT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_halted && !send_xoff && !send_xon) |-> !ser_tx_valid); // R6

endmodule

// File: tb/tb_uart_fifo_flow.sv
module tb_uart_fifo_flow;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] cfg_rx_trig = 6'd8, cfg_tx_trig = 6'd4;
    logic [2:0] cfg_hyst = 3'd3;
    logic       cfg_auto_rts = 1'b1, cfg_auto_cts = 1'b1, cfg_sw_flow = 1'b0;
    logic [7:0] cfg_xon = 8'h11, cfg_xoff = 8'h13;
    logic       cfg_special_en = 1'b1;
    logic [7:0] cfg_special = 8'h7E;
    logic       clr_flags = 1'b0, host_tx_wr = 1'b0, host_rx_rd = 1'b0;
    logic [7:0] host_tx_data = '0, ser_rx_data = '0;
    logic       ser_rx_valid = 1'b0, ser_tx_ready = 1'b0, cts_n = 1'b0;
    logic [7:0] host_rx_data, ser_tx_data;
    logic [5:0] rx_level, tx_level;
    logic       rx_empty, rx_irq, tx_irq, ser_tx_valid, rts_n;
    logic       tx_halted, overrun, special_seen;

    int checks = 0, failures = 0;
    bit cmp_on = 0, done = 0;

    always #4 clk = ~clk;

    uart_fifo_flow dut (.*);

    // Behavioural reference
    byte unsigned rxq[$], txq[$];
    int  m_lf = 0;      // 0 run, 1 xoff pending, 2 held, 3 xon pending
    bit  m_rts_off = 0, m_stop = 0, m_ovr = 0, m_sp = 0;

    function automatic int m_sel();
        if (m_lf == 1) return 1;
        if (m_lf == 3) return 2;
        if (!m_stop && txq.size() > 0) return 3;
        return 0;
    endfunction

    function automatic bit m_valid();
        return (!cfg_auto_cts || !cts_n) && (m_sel() != 0);
    endfunction

    function automatic int m_data();
        case (m_sel())
            1: return cfg_xoff;
            2: return cfg_xon;
            3: return txq[0];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_lf = 0; m_rts_off = 0; m_stop = 0; m_ovr = 0; m_sp = 0;
        end else begin
            int rl, tl, sel, res;
            bit taken, ovr_set, sp_set, halt, resume;
            rl = rxq.size(); tl = txq.size();
            sel = m_sel();
            taken = m_valid() && ser_tx_ready;
            res = (cfg_rx_trig > cfg_hyst) ? cfg_rx_trig - cfg_hyst : 0;
            halt = (rl >= cfg_rx_trig);
            resume = (rl < cfg_rx_trig) && (rl <= res);
            ovr_set = 0; sp_set = 0;
            if (rx_valid_in()) begin
                if (cfg_sw_flow && ser_rx_data == cfg_xoff) m_stop = 1;
                else if (cfg_sw_flow && ser_rx_data == cfg_xon) m_stop = 0;
                else begin
                    if (rl == 32) ovr_set = 1;
                    if (cfg_special_en && ser_rx_data == cfg_special) sp_set = 1;
                end
            end
            if (!cfg_sw_flow) m_stop = 0;
            if (host_rx_rd && rl > 0) void'(rxq.pop_front());
            if (rx_valid_in() && !(cfg_sw_flow && (ser_rx_data == cfg_xoff || ser_rx_data == cfg_xon)) && rl < 32)
                rxq.push_back(ser_rx_data);
            if (ovr_set) m_ovr = 1; else if (clr_flags) m_ovr = 0;
            if (sp_set) m_sp = 1; else if (clr_flags) m_sp = 0;
            if (taken && sel == 3) void'(txq.pop_front());
            if (host_tx_wr && tl < 32) txq.push_back(host_tx_data);
            if (!cfg_sw_flow) m_lf = 0;
            else case (m_lf)
                0: if (halt) m_lf = 1;
                1: if (taken && sel == 1) m_lf = 2;
                2: if (resume) m_lf = 3;
                3: if (taken && sel == 2) m_lf = 0;
                default: m_lf = 0;
            endcase
            if (!m_rts_off) begin
                if (cfg_auto_rts && halt) m_rts_off = 1;
            end else if (!cfg_auto_rts || resume) m_rts_off = 0;
        end
    end

    function automatic bit rx_valid_in();
        return ser_rx_valid;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1", "rx_level", rx_level, rxq.size());
            chk("R1", "tx_level", tx_level, txq.size());
            chk("R11", "rx_empty", rx_empty, rxq.size() == 0);
            if (rxq.size() > 0) chk("R11", "host_rx_data", host_rx_data, rxq[0]);
            chk("R3", "rx_irq", rx_irq, rxq.size() >= cfg_rx_trig);
            chk("R3", "tx_irq", tx_irq, txq.size() <= cfg_tx_trig);
            chk("R4", "rts_n", rts_n, m_rts_off);
            chk("R5", "ser_tx_valid", ser_tx_valid, m_valid());
            if (m_valid()) chk("R8", "ser_tx_data", ser_tx_data, m_data());
            chk("R6", "tx_halted", tx_halted, m_stop);
            chk("R2", "overrun", overrun, m_ovr);
            chk("R7", "special_seen", special_seen, m_sp);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic rx_push(input byte unsigned b);
        ser_rx_valid = 1; ser_rx_data = b; cyc(1); ser_rx_valid = 0;
    endtask

    task automatic tx_write(input byte unsigned b);
        host_tx_wr = 1; host_tx_data = b; cyc(1); host_tx_wr = 0;
    endtask

    task automatic rx_read(input int n);
        host_rx_rd = 1; cyc(n); host_rx_rd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1; #1;
        chk("R1", "reset rx_level", rx_level, 0);
        chk("R1", "reset tx_level", tx_level, 0);
        chk("R4", "reset rts_n", rts_n, 0);
        chk("R5", "reset ser_tx_valid", ser_tx_valid, 0);
        chk("R6", "reset tx_halted", tx_halted, 0);
        #1; cmp_on = 1;

        // Transmit queue overfill, CTS gating, ordered drain
        for (int i = 0; i < 34; i++) tx_write(byte'(i * 7 + 1));
        cyc(2); #1;
        chk("R1", "tx full drop", tx_level, 32);
        #0 cts_n = 1; ser_tx_ready = 1;
        cyc(5); #1;
        chk("R5", "cts blocks", ser_tx_valid, 0);
        cts_n = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(1); ser_tx_ready = (i % 3 != 2); cts_n = (i % 5 == 4);
        end
        cts_n = 0; ser_tx_ready = 1; cyc(20); #1;
        chk("R11", "tx drained", tx_level, 0);
        ser_tx_ready = 0;

        // Receive trigger, RTS hysteresis, special, overrun
        for (int i = 0; i < 10; i++) rx_push((i == 3) ? 8'h7E : byte'(8'h40 + i));
        cyc(2); #1;
        chk("R3", "rx_irq at 10", rx_irq, 1);
        chk("R4", "rts off", rts_n, 1);
        chk("R7", "special flag", special_seen, 1);
        rx_read(4); cyc(2); #1;
        chk("R4", "rts held in band", rts_n, 1);
        rx_read(1); cyc(2); #1;
        chk("R4", "rts resumed", rts_n, 0);
        clr_flags = 1; cyc(1); clr_flags = 0;
        for (int i = 0; i < 30; i++) rx_push(byte'(8'h80 + i));
        cyc(2); #1;
        chk("R2", "overrun set", overrun, 1);
        chk("R1", "rx full", rx_level, 32);
        clr_flags = 1; cyc(1); clr_flags = 0; cyc(1); #1;
        chk("R2", "overrun cleared", overrun, 0);
        rx_read(32); cyc(2);

        // Software flow control
        cfg_sw_flow = 1;
        for (int i = 0; i < 3; i++) tx_write(byte'(8'hA0 + i));
        rx_push(8'h13); cyc(2); #1;
        chk("R6", "halted", tx_halted, 1);
        chk("R6", "xoff not stored", rx_level, 0);
        chk("R6", "data held", ser_tx_valid, 0);
        rx_push(8'h11); cyc(2); #1;
        chk("R6", "resumed", tx_halted, 0);
        rx_push(8'h13);
        for (int i = 0; i < 8; i++) rx_push(byte'(8'h20 + i));
        cyc(2); #1;
        chk("R8", "xoff offered", ser_tx_valid, 1);
        chk("R8", "xoff value", ser_tx_data, 8'h13);
        ser_tx_ready = 1; cyc(1); ser_tx_ready = 0;
        rx_read(3); cyc(3); #1;
        chk("R9", "xon offered", ser_tx_valid, 1);
        chk("R9", "xon value", ser_tx_data, 8'h11);
        ser_tx_ready = 1; cyc(1);
        rx_push(8'h11); cyc(8);
        ser_tx_ready = 0;
        rx_read(8); cyc(2);

        // Flow characters as plain data
        cfg_sw_flow = 0; cyc(1);
        rx_push(8'h13); rx_push(8'h11); cyc(2); #1;
        chk("R10", "xoff stored", host_rx_data, 8'h13);
        chk("R10", "not halted", tx_halted, 0);
        for (int i = 0; i < 7; i++) rx_push(byte'(i));
        cyc(2); #1;
        chk("R4", "rts off again", rts_n, 1);
        cfg_auto_rts = 0; cyc(2); #1;
        chk("R4", "auto rts off", rts_n, 0);
        cyc(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule